// File: doc/BRIEF.md
# Flash Write-Completion Poller

This engine runs on the host side and decides when a program or erase operation inside a parallel flash device has finished. A request carries the address being written and the data expected there. The engine then issues status reads, one at a time, through a request/acknowledge read port. It judges each returned word with one of two methods, chosen per request:

- **Data-level comparison:** bit 7 of the returned word is compared with bit 7 of the expected data.
- **Toggle comparison:** bit 6 of the returned word is compared with bit 6 of the previous read.

The device finishes its operation asynchronously to the host. A single status read can therefore land exactly on the moment of completion and return an inconsistent word. To guard against this, the engine does not accept the first passing read on its own. It takes two more reads of the same location, and it reports completion only when both of them also pass. If either of those reads fails, the engine goes back to searching.

Every acknowledged read counts as one poll. If a sequence uses up its poll budget without reaching completion, the engine raises a timeout error and returns to idle. Only the status evaluation is in scope: the command sequences and the bus timing belong to other blocks.

Top module: `wrdone_poller`

## Requirements
- R1: While reset is asserted, and in the cycle after it, `done`, `timeout_err`, `busy` and `rd_req` are all low.
- R2: When `start` is high and the engine is idle, the engine accepts the request at that clock edge. From the next cycle, `busy` and `rd_req` are high and `rd_addr` equals the `start_addr` captured at acceptance.
- R3: `rd_req` stays high and `rd_addr` stays unchanged until `rd_ack` is sampled high. Each cycle in which both `rd_req` and `rd_ack` are high completes exactly one read, whose word is taken from `rd_data` in that cycle.
- R4: With `use_toggle` = 0 at acceptance, a read passes when `rd_data[7]` equals bit 7 of `start_data` captured at acceptance.
- R5: With `use_toggle` = 1 at acceptance, a read passes when `rd_data[6]` equals bit 6 of the previous read in the same sequence. The first read of a sequence never passes.
- R6: The first passing read is followed by two more reads. If both pass, `done` is high for the one cycle after the edge that takes the second of them, and `busy` and `rd_req` are low in that same cycle.
- R7: If either of the two extra reads fails, the engine resumes searching. It then needs a new passing read followed by two more passing reads before it reports completion.
- R8: `poll_limit` is captured at acceptance, and every completed read counts as one poll. When the read numbered max(`poll_limit`, 1) completes without completing the sequence, `timeout_err` is high for the next cycle and the engine goes idle. If that same read completes the sequence, `done` is reported instead.
- R9: A `start` pulse while `busy` is high has no effect: `rd_addr` keeps its value and the running sequence continues unchanged.
- R10: `done` and `timeout_err` are never high together, and each stays high for a single cycle per sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin a polling sequence |
| start_addr | input | ADDR_W | Location to poll |
| start_data | input | DATA_W | Data expected at that location once the write is complete |
| use_toggle | input | 1 | 1 selects toggle comparison on bit 6; 0 selects data-level comparison on bit 7 |
| poll_limit | input | CNT_W | Maximum number of reads allowed per sequence |
| rd_req | output | 1 | Read request; held high until it is acknowledged |
| rd_addr | output | ADDR_W | Address for the read request |
| rd_ack | input | 1 | Read acknowledge; `rd_data` is valid in the same cycle |
| rd_data | input | DATA_W | Returned status word |
| busy | output | 1 | A polling sequence is active |
| done | output | 1 | One-cycle pulse: completion confirmed |
| timeout_err | output | 1 | One-cycle pulse: poll budget used up |

## Verification
The timing of each output is fixed relative to the clock edge that causes it:

- `busy` and `rd_req` rise, and `rd_addr` takes the new value, one edge after an accepted `start`.
- A verdict appears in the cycle right after the edge that takes the deciding acknowledged read. `done` or `timeout_err` pulses in that cycle, and `busy` drops in the same cycle.

The bench drives each acknowledge for exactly one cycle and samples on the falling edge that follows it. A reference function, working from the list of returned words, predicts which read ends the sequence and which pulse it gives. The bench also checks that no verdict appears after any earlier read, and that no pulse remains one cycle after the verdict.

// File: rtl/wrdone_pkg.sv
package wrdone_pkg;

    // Position of the data-level status bit in a returned status word.
    localparam int POLL_BIT = 7;
    // Position of the toggling status bit in a returned status word.
    localparam int TGL_BIT = 6;
    // Number of reads that must confirm a first passing read.
    localparam int EXTRA_READS = 2;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_SEEK    = 2'd1,
        PH_CONFIRM = 2'd2
    } phase_e;

    // Per-sequence settings, captured when a request is accepted.
    typedef struct packed {
        logic toggle_mode;
        logic exp_bit;
    } job_cfg_t;

    function automatic logic level_match(input logic a, input logic b);
        return a == b;
    endfunction

endpackage

// File: rtl/wrdone_read_port.sv
module wrdone_read_port #(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              active,
    input  logic              rd_ack,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              taken
);
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= load_addr;
        end
    end

    // Only one read is ever outstanding: the request stays up for the
    // whole active sequence, and each acknowledge closes one read.
    assign rd_req  = active;
    assign rd_addr = addr_q;
    assign taken   = active && rd_ack;
endmodule

// File: rtl/wrdone_status_judge.sv
module wrdone_status_judge
    import wrdone_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              sample,
    input  job_cfg_t          cfg,
    input  logic [DATA_W-1:0] rd_data,
    output logic              read_ok
);
    logic have_ref;
    logic prev_tgl;

    // Keep bit 6 of the last read so that toggle mode can compare against it.
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            have_ref <= 1'b0;
            prev_tgl <= 1'b0;
        end else if (sample) begin
            have_ref <= 1'b1;
            prev_tgl <= rd_data[TGL_BIT];
        end
    end

    always_comb begin
        if (cfg.toggle_mode) begin
            read_ok = have_ref && level_match(rd_data[TGL_BIT], prev_tgl);
        end else begin
            read_ok = level_match(rd_data[POLL_BIT], cfg.exp_bit);
        end
    end
endmodule

// File: rtl/wrdone_poll_counter.sv
module wrdone_poll_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             step,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);
    logic [CNT_W-1:0] count;
    logic [CNT_W:0]   count_nx;

    assign count_nx = {1'b0, count} + {{CNT_W{1'b0}}, 1'b1};
    // A limit of zero expires on the first read, so it acts like a limit of one.
    assign expire   = step && (count_nx >= {1'b0, limit});

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
        end else if (step && (count != {CNT_W{1'b1}})) begin
            count <= count_nx[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/wrdone_poller.sv
module wrdone_poller
    import wrdone_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [DATA_W-1:0] start_data,
    input  logic              use_toggle,
    input  logic [CNT_W-1:0]  poll_limit,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              done,
    output logic              timeout_err
);
    localparam int LEFT_W = $clog2(EXTRA_READS + 1);

    phase_e           phase;
    job_cfg_t         cfg;
    logic [LEFT_W-1:0] left;
    logic [CNT_W-1:0] limit_q;
    logic             accept;
    logic             active;
    logic             taken;
    logic             read_ok;
    logic             expire;
    logic             finish;

    assign active = (phase != PH_IDLE);
    assign accept = (phase == PH_IDLE) && start;
    assign busy   = active;

    wrdone_read_port #(.ADDR_W(ADDR_W)) u_port (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .load_addr (start_addr),
        .active    (active),
        .rd_ack    (rd_ack),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .taken     (taken)
    );

    wrdone_status_judge #(.DATA_W(DATA_W)) u_judge (
        .clk     (clk),
        .rst     (rst),
        .clear   (accept),
        .sample  (taken),
        .cfg     (cfg),
        .rd_data (rd_data),
        .read_ok (read_ok)
    );

    wrdone_poll_counter #(.CNT_W(CNT_W)) u_count (
        .clk    (clk),
        .rst    (rst),
        .clear  (accept),
        .step   (taken),
        .limit  (limit_q),
        .expire (expire)
    );

    // The sequence completes on the last of the confirming reads.
    assign finish = taken && read_ok && (phase == PH_CONFIRM)
                    && (left == LEFT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase           <= PH_IDLE;
            cfg.toggle_mode <= 1'b0;
            cfg.exp_bit     <= 1'b0;
            left            <= '0;
            limit_q         <= '0;
            done            <= 1'b0;
            timeout_err     <= 1'b0;
        end else begin
            done        <= 1'b0;
            timeout_err <= 1'b0;
            if (accept) begin
                phase           <= PH_SEEK;
                cfg.toggle_mode <= use_toggle;
                cfg.exp_bit     <= start_data[POLL_BIT];
                limit_q         <= poll_limit;
                left            <= '0;
            end else if (taken) begin
                if (finish) begin
                    done  <= 1'b1;
                    phase <= PH_IDLE;
                end else if (expire) begin
                    timeout_err <= 1'b1;
                    phase       <= PH_IDLE;
                end else if (read_ok) begin
                    if (phase == PH_SEEK) begin
                        phase <= PH_CONFIRM;
                        left  <= LEFT_W'(EXTRA_READS);
                    end else begin
                        left <= left - LEFT_W'(1);
                    end
                end else begin
                    // A failing read at any point restarts the search.
                    phase <= PH_SEEK;
                end
            end
        end
    end
endmodule

// File: rtl/wrdone_checks.sv
module wrdone_checks #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              rd_req,
    input logic              rd_ack,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              busy,
    input logic              done,
    input logic              timeout_err
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!done && !timeout_err && !busy && !rd_req));

    assert_req_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_ack) |=> rd_req);

    assert_addr_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_ack) |=> $stable(rd_addr));

    assert_done_after_read_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(rd_req && rd_ack));

    assert_idle_on_verdict_R6: assert property (@(posedge clk) disable iff (rst)
        (done || timeout_err) |-> (!busy && !rd_req));

    assert_err_after_read_R8: assert property (@(posedge clk) disable iff (rst)
        timeout_err |-> $past(rd_req && rd_ack));

    assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(rd_addr));

    assert_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
        !(done && timeout_err));

    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        (done || timeout_err) |=> !(done || timeout_err));
endmodule

bind wrdone_poller wrdone_checks #(.ADDR_W(ADDR_W)) u_checks (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .rd_req      (rd_req),
    .rd_ack      (rd_ack),
    .rd_addr     (rd_addr),
    .busy        (busy),
    .done        (done),
    .timeout_err (timeout_err)
);

// File: tb/test_wrdone_poller.sv
`timescale 1ns/1ps
module test_wrdone_poller;
    localparam int ADDR_W = 20;
    localparam int DATA_W = 16;
    localparam int CNT_W  = 16;
    localparam int NRD    = 40;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] start_addr = '0;
    logic [DATA_W-1:0] start_data = '0;
    logic              use_toggle = 1'b0;
    logic [CNT_W-1:0]  poll_limit = '0;
    logic              rd_req;
    logic [ADDR_W-1:0] rd_addr;
    logic              rd_ack = 1'b0;
    logic [DATA_W-1:0] rd_data = '0;
    logic              busy;
    logic              done;
    logic              timeout_err;

    int vectors = 0;
    int fails   = 0;
    logic [DATA_W-1:0] rv [NRD];
    int  exp_n;
    bit  exp_done;

    always #2.5 clk = ~clk;

    wrdone_poller #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) i_wrdone_poller (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
        .start_data(start_data), .use_toggle(use_toggle), .poll_limit(poll_limit),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
        .busy(busy), .done(done), .timeout_err(timeout_err)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Reference model: walks the word list, returns the deciding read and the verdict.
    task automatic predict(input bit mode, input bit exp7, input int lim);
        bit seeking = 1'b1;
        int left = 0;
        bit have = 1'b0;
        bit prev = 1'b0;
        int eff = (lim == 0) ? 1 : lim;
        exp_n = NRD;
        exp_done = 1'b0;
        for (int i = 0; i < NRD; i++) begin
            bit ok;
            ok = mode ? (have && (rv[i][6] == prev)) : (rv[i][7] == exp7);
            have = 1'b1;
            prev = rv[i][6];
            if (ok) begin
                if (seeking) begin
                    seeking = 1'b0;
                    left = 2;
                end else begin
                    left--;
                    if (left == 0) begin
                        exp_n = i + 1;
                        exp_done = 1'b1;
                        return;
                    end
                end
            end else begin
                seeking = 1'b1;
            end
            if (i + 1 >= eff) begin
                exp_n = i + 1;
                exp_done = 1'b0;
                return;
            end
        end
    endtask

    // Word list: still busy for the first b reads, then complete, with optional glitches.
    task automatic fill(input bit mode, input bit exp7, input int b, input int glitch);
        bit c = 1'($urandom % 2);
        for (int i = 0; i < NRD; i++) begin
            logic [DATA_W-1:0] w;
            w = DATA_W'($urandom);
            if (i < b) begin
                if (mode) w[6] = 1'(i % 2);
                else      w[7] = ~exp7;
            end else begin
                if (mode) w[6] = c;
                else      w[7] = exp7;
            end
            if (glitch > 0 && ($urandom % glitch) == 0) begin
                if (mode) w[6] = ~w[6];
                else      w[7] = ~w[7];
            end
            rv[i] = w;
        end
    endtask

    task automatic run_seq(input bit mode, input logic [DATA_W-1:0] data, input int lim,
                           input bit inject, input string tag);
        logic [ADDR_W-1:0] a = ADDR_W'($urandom);
        predict(mode, data[7], lim);
        @(negedge clk);
        start = 1'b1; start_addr = a; start_data = data;
        use_toggle = mode; poll_limit = CNT_W'(lim);
        @(negedge clk);
        start = 1'b0;
        chk(busy && rd_req, "R2 busy/rd_req", {30'd0, busy, rd_req}, 32'h3);
        chk(rd_addr == a, "R2 rd_addr", 32'(rd_addr), 32'(a));
        if (inject) begin
            start = 1'b1; start_addr = ~a; use_toggle = ~mode; poll_limit = '0;
            @(negedge clk);
            start = 1'b0;
            chk(rd_addr == a && busy, "R9 start ignored", 32'(rd_addr), 32'(a));
        end
        for (int i = 0; i < exp_n; i++) begin
            int gap = int'($urandom % 3);
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                chk(rd_req && rd_addr == a, "R3 request held", 32'(rd_req), 32'h1);
            end
            rd_ack = 1'b1; rd_data = rv[i];
            @(negedge clk);
            rd_ack = 1'b0; rd_data = DATA_W'($urandom);
            if (i < exp_n - 1) begin
                chk(!done && !timeout_err && busy, "R7 no early verdict",
                    {29'd0, done, timeout_err, busy}, 32'h1);
            end else begin
                chk(done == exp_done && timeout_err == !exp_done && !busy && !rd_req,
                    exp_done ? {tag, " R6 done"} : {tag, " R8 timeout"},
                    {29'd0, done, timeout_err, busy}, {29'd0, exp_done, !exp_done, 1'b0});
            end
        end
        @(negedge clk);
        chk(!done && !timeout_err, "R10 single pulse", {30'd0, done, timeout_err}, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h1d2c_3b4a));
        repeat (3) @(negedge clk);
        chk(!done && !timeout_err && !busy && !rd_req, "R1 reset",
            {28'd0, done, timeout_err, busy, rd_req}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(!done && !timeout_err && !busy && !rd_req, "R1 after reset",
            {28'd0, done, timeout_err, busy, rd_req}, 32'h0);

        // Data-level: passes at once, done on read 3.
        fill(1'b0, 1'b1, 0, 0);
        run_seq(1'b0, 16'h0080, 10, 1'b0, "R4");
        // Toggle: the first read is only a reference, done on read 4.
        fill(1'b1, 1'b0, 0, 0);
        run_seq(1'b1, 16'h0000, 10, 1'b0, "R5");
        // A failing confirming read restarts the search: done on read 5.
        fill(1'b0, 1'b0, 0, 0);
        rv[1][7] = 1'b1;
        run_seq(1'b0, 16'h0000, 10, 1'b0, "R7");
        // Completion on the last allowed read wins over the timeout.
        fill(1'b0, 1'b1, 0, 0);
        run_seq(1'b0, 16'h00ff, 3, 1'b0, "R8 priority");
        // Budget too small.
        fill(1'b0, 1'b1, 0, 0);
        run_seq(1'b0, 16'h00ff, 2, 1'b0, "R8 limit2");
        // A limit of zero acts as one.
        fill(1'b1, 1'b1, 0, 0);
        run_seq(1'b1, 16'h0000, 0, 1'b0, "R8 limit0");
        // Start while busy is ignored.
        fill(1'b1, 1'b0, 5, 0);
        run_seq(1'b1, 16'h1234, 20, 1'b1, "R9");

        for (int s = 0; s < 150; s++) begin
            bit m = 1'($urandom % 2);
            logic [DATA_W-1:0] d = DATA_W'($urandom);
            int b = int'($urandom % 12);
            int lim = int'($urandom % 37);
            fill(m, d[7], b, int'($urandom % 2) * 6);
            run_seq(m, d, lim, 1'($urandom % 4 == 0), m ? "R5 random" : "R4 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule